// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small fully associative store. Every cell carries a data word plus one extra bit that records whether the cell holds a word. A command compares a key against all cells in the same clock. Only the bit positions selected by a mask take part in the comparison. The result is a per-cell hit vector, a hit count, and a zero/one/several summary. The lowest-numbered hit is resolved by a fixed priority encoder.

A read returns the data of the lowest-numbered hit, or is cancelled when nothing hits. A write reuses the same comparison path with a fixed key and mask that select only the occupancy bit. This marks every free cell. The new word is then stored in the lowest free cell. When no cell is free, the write is refused and a full pulse is raised for that command.

Top module: `mcam_top`

## Requirements
- R1: After reset every cell is free with all-zero data. The hit vector and hit count are 0, `st_none` is 1, `st_one` and `st_many` are 0, `hit_valid` is 0, and `rd_valid`, `full` and `op_done` are 0.
- R2: `cmd_op` encodes 0 = no operation, 1 = search, 2 = read, 3 = write. For search and read, cell j hits when ((data_j XOR key) AND mask) is zero. The occupancy bit is excluded, so a free cell with zero data hits a zero key. Results appear on the registered outputs one clock after the command is accepted, together with a one-cycle `op_done` pulse.
- R3: `hit_count` equals the number of ones in `hit_vec` for the last command.
- R4: Exactly one of `st_none` (no hit), `st_one` (exactly one hit) and `st_many` (two or more hits) is 1 at all times.
- R5: A read with no hit is cancelled: `rd_valid` is 0 and `rd_data` is 0. A read with one or more hits pulses `rd_valid` and returns the data of the lowest-numbered hit.
- R6: `hit_valid` is 1 exactly when some cell hit. `hit_index` is then the lowest bit position set in `hit_vec`.
- R7: A write marks every free cell in `hit_vec`, sampled before the store. It stores `wr_data` into the lowest free cell and sets that cell's occupancy bit, so later searches find the word.
- R8: A write when no cell is free changes no cell and raises `full` for one cycle together with `op_done`.
- R9: While `cmd_valid` is 0 or the op is "no operation", the cells, `hit_vec`, `hit_count` and the status flags hold, and `op_done`, `rd_valid` and `full` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code (see R2) |
| key | input | DATA_W | Comparison key |
| mask | input | DATA_W | Comparison mask, 1 = compare this bit |
| wr_data | input | DATA_W | Word to store on write |
| rd_data | output | DATA_W | Word returned by a read |
| rd_valid | output | 1 | Read returned a word |
| hit_vec | output | NUM_CELLS | Per-cell hit vector of last command |
| hit_count | output | clog2(NUM_CELLS+1) | Number of hits |
| st_none | output | 1 | No cell hit |
| st_one | output | 1 | Exactly one cell hit |
| st_many | output | 1 | Two or more cells hit |
| hit_index | output | clog2(NUM_CELLS) | Lowest hit position |
| hit_valid | output | 1 | hit_index is meaningful |
| full | output | 1 | Write refused, no free cell |
| op_done | output | 1 | Registered results updated this cycle |

## Verification
Some properties are checked on every cycle by the assertions:
- exactly one status flag is set;
- the hit count agrees with the hit vector;
- the reported index is the lowest set bit;
- a returned read implies a hit;
- a refused write leaves the array untouched;
- a successful write leaves the stored word with its occupancy bit set.

Other behaviour is shown only by the bench scenarios, which compare against an independent model:
- masked comparison with partial masks;
- free zero cells hitting a zero key;
- filling the array in lowest-free order;
- the ninth write being refused;
- outputs holding while idle.

// File: rtl/mcam_pkg.sv
// Shared types for the masked content-addressable memory.
package mcam_pkg;
    typedef enum logic [1:0] {
        CAM_NOP    = 2'd0,
        CAM_SEARCH = 2'd1,
        CAM_READ   = 2'd2,
        CAM_WRITE  = 2'd3
    } cam_op_e;
endpackage

// File: rtl/mcam_compare.sv
// Parallel masked comparison of one key against every cell.
// Assumes cells are {occupancy, data}; key and mask already extended to that width.
module mcam_compare #(
    parameter int NUM_CELLS = 8,
    parameter int CELL_W    = 9
) (
    input  logic [NUM_CELLS-1:0][CELL_W-1:0] cells,
    input  logic [CELL_W-1:0]                key_ext,
    input  logic [CELL_W-1:0]                mask_ext,
    output logic [NUM_CELLS-1:0]             hits
);
    // one comparator per cell: every masked bit must agree with the key
    for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
        assign hits[g] = ~|((cells[g] ^ key_ext) & mask_ext);
    end
endmodule

// File: rtl/mcam_prio.sv
// Fixed-priority encoder: lowest set bit wins. Assumes NUM_CELLS >= 2.
module mcam_prio #(
    parameter int NUM_CELLS = 8,
    localparam int IDX_W    = $clog2(NUM_CELLS)
) (
    input  logic [NUM_CELLS-1:0] vec,
    output logic [IDX_W-1:0]     idx,
    output logic                 any
);
    // scan from the top so the lowest set position is the last assignment
    always_comb begin
        idx = '0;
        for (int i = NUM_CELLS - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/mcam_count.sv
// Population count of the hit vector and the zero/one/several summary.
// The "one" flag uses the single-bit test, independent of the adder tree.
module mcam_count #(
    parameter int NUM_CELLS = 8,
    localparam int CNT_W    = $clog2(NUM_CELLS + 1)
) (
    input  logic [NUM_CELLS-1:0] vec,
    output logic [CNT_W-1:0]     cnt,
    output logic                 none,
    output logic                 one,
    output logic                 many
);
    // sum the hit bits
    always_comb begin
        cnt = '0;
        for (int i = 0; i < NUM_CELLS; i++) cnt = cnt + CNT_W'(vec[i]);
    end

    // summary flags: zero, a single bit, otherwise several
    always_comb begin
        none = ~|vec;
        one  = ~none && ((vec & (vec - NUM_CELLS'(1))) == '0);
        many = ~none && ~one;
    end
endmodule

// File: rtl/mcam_top.sv
// Masked content-addressable memory: NUM_CELLS cells of {occupancy, DATA_W data}.
// Search/read compare data bits only; write searches for free cells by occupancy.
// All commands complete in one clock; results are registered. Synchronous active-low reset.
module mcam_top
    import mcam_pkg::*;
#(
    parameter int NUM_CELLS = 8,
    parameter int DATA_W    = 8,
    localparam int CELL_W   = DATA_W + 1,
    localparam int IDX_W    = $clog2(NUM_CELLS),
    localparam int CNT_W    = $clog2(NUM_CELLS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [DATA_W-1:0]    key,
    input  logic [DATA_W-1:0]    mask,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic [NUM_CELLS-1:0] hit_vec,
    output logic [CNT_W-1:0]     hit_count,
    output logic                 st_none,
    output logic                 st_one,
    output logic                 st_many,
    output logic [IDX_W-1:0]     hit_index,
    output logic                 hit_valid,
    output logic                 full,
    output logic                 op_done
);
    cam_op_e op;
    logic [NUM_CELLS-1:0][CELL_W-1:0] cells_q;
    logic [CELL_W-1:0]    key_ext, mask_ext;
    logic [NUM_CELLS-1:0] cur_vec;
    logic [IDX_W-1:0]     cur_idx;
    logic                 cur_any;
    logic [CNT_W-1:0]     cur_cnt;
    logic                 cur_none, cur_one, cur_many;
    logic                 act;
    cam_op_e              last_op_q;

    assign op  = cam_op_e'(cmd_op);
    assign act = cmd_valid && (op != CAM_NOP);

    // choose comparison operands: free-cell probe for writes, masked data otherwise
    always_comb begin
        if (op == CAM_WRITE) begin
            key_ext  = {1'b0, {DATA_W{1'b1}}};
            mask_ext = {1'b1, {DATA_W{1'b0}}};
        end else begin
            key_ext  = {1'b0, key};
            mask_ext = {1'b0, mask};
        end
    end

    mcam_compare #(.NUM_CELLS(NUM_CELLS), .CELL_W(CELL_W)) u_cmp (
        .cells(cells_q), .key_ext(key_ext), .mask_ext(mask_ext), .hits(cur_vec)
    );

    mcam_prio #(.NUM_CELLS(NUM_CELLS)) u_prio (
        .vec(cur_vec), .idx(cur_idx), .any(cur_any)
    );

    mcam_count #(.NUM_CELLS(NUM_CELLS)) u_cnt (
        .vec(cur_vec), .cnt(cur_cnt), .none(cur_none), .one(cur_one), .many(cur_many)
    );

    // register results, perform the store, and raise the per-command pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells_q   <= '0;
            hit_vec   <= '0;
            hit_count <= '0;
            st_none   <= 1'b1;
            st_one    <= 1'b0;
            st_many   <= 1'b0;
            hit_index <= '0;
            hit_valid <= 1'b0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            full      <= 1'b0;
            op_done   <= 1'b0;
            last_op_q <= CAM_NOP;
        end else begin
            op_done  <= 1'b0;
            rd_valid <= 1'b0;
            full     <= 1'b0;
            if (act) begin
                hit_vec   <= cur_vec;
                hit_count <= cur_cnt;
                st_none   <= cur_none;
                st_one    <= cur_one;
                st_many   <= cur_many;
                hit_index <= cur_idx;
                hit_valid <= cur_any;
                op_done   <= 1'b1;
                last_op_q <= op;
                if (op == CAM_READ) begin
                    rd_valid <= cur_any;
                    rd_data  <= cur_any ? cells_q[cur_idx][DATA_W-1:0] : '0;
                end
                if (op == CAM_WRITE) begin
                    if (cur_any) cells_q[cur_idx] <= {1'b1, wr_data};
                    else         full <= 1'b1;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    p_flag_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({st_none, st_one, st_many}) == 1)
        else $error("R4 status flags not one-hot");

    p_count_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count == CNT_W'($countones(hit_vec)))
        else $error("R3 hit_count disagrees with hit_vec");

    p_lowest_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (hit_vec[hit_index] &&
                       ((hit_vec & ((NUM_CELLS'(1) << hit_index) - NUM_CELLS'(1))) == '0)))
        else $error("R6 hit_index not the lowest hit");

    p_read_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (hit_valid && op_done))
        else $error("R5 read returned without a hit");

    p_full_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (st_none && cells_q == $past(cells_q)))
        else $error("R8 refused write changed the array");

    p_write_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && last_op_q == CAM_WRITE && !full) |->
            (cells_q[hit_index] == {1'b1, $past(wr_data)}))
        else $error("R7 write did not store the word");

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_done |-> (!rd_valid && !full))
        else $error("R9 pulse without a command");
endmodule

// File: tb/mcam_top_bench.sv
`timescale 1ns/1ps
module mcam_top_bench;
    localparam int N = 8;
    localparam int W = 8;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0;
    logic [1:0] cmd_op = 0;
    logic [W-1:0] key = 0, mask = 0, wr_data = 0;
    logic [W-1:0] rd_data;
    logic rd_valid, st_none, st_one, st_many, hit_valid, full, op_done;
    logic [N-1:0] hit_vec;
    logic [3:0] hit_count;
    logic [2:0] hit_index;

    always #2.5 clk = ~clk;

    mcam_top #(.NUM_CELLS(N), .DATA_W(W)) u_mcam_top (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .key(key), .mask(mask), .wr_data(wr_data), .rd_data(rd_data),
        .rd_valid(rd_valid), .hit_vec(hit_vec), .hit_count(hit_count),
        .st_none(st_none), .st_one(st_one), .st_many(st_many),
        .hit_index(hit_index), .hit_valid(hit_valid), .full(full), .op_done(op_done)
    );

    typedef struct {
        logic [N-1:0] vec; int cnt; logic none, one, many;
        int hidx; logic hv; logic is_read; logic rdv; logic [W-1:0] rdd; logic full;
    } exp_t;

    exp_t sb_q[$];
    int compared = 0, mismatched = 0;
    bit finished = 0;
    logic [W-1:0] m_data [N];
    logic         m_occ  [N];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: compute the expectation from the model, push it, issue the command
    task automatic issue(input int op, input logic [W-1:0] k, input logic [W-1:0] m,
                         input logic [W-1:0] d);
        exp_t e;
        e.vec = '0;
        for (int j = 0; j < N; j++)
            e.vec[j] = (op == 3) ? !m_occ[j] : (((m_data[j] ^ k) & m) == '0);
        e.cnt = $countones(e.vec);
        e.none = (e.cnt == 0); e.one = (e.cnt == 1); e.many = (e.cnt > 1);
        e.hv = (e.cnt != 0); e.hidx = 0;
        for (int j = N - 1; j >= 0; j--) if (e.vec[j]) e.hidx = j;
        e.is_read = (op == 2);
        e.rdv = e.is_read && e.hv;
        e.rdd = e.rdv ? m_data[e.hidx] : '0;
        e.full = (op == 3) && !e.hv;
        if (op == 3 && e.hv) begin m_data[e.hidx] = d; m_occ[e.hidx] = 1; end
        sb_q.push_back(e);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'(op); key = k; mask = m; wr_data = d;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 0;
    endtask

    // monitor: compare each completed command against the oldest expectation
    always @(negedge clk) begin
        if (rst_n && op_done) begin
            exp_t e;
            if (sb_q.size() == 0) chk(0, "R2", "unexpected op_done", 1, 0);
            else begin
                e = sb_q.pop_front();
                chk(hit_vec == e.vec, "R2", "hit_vec", int'(hit_vec), int'(e.vec));
                chk(hit_count == e.cnt, "R3", "hit_count", int'(hit_count), e.cnt);
                chk({st_none, st_one, st_many} == {e.none, e.one, e.many}, "R4", "flags",
                    int'({st_none, st_one, st_many}), int'({e.none, e.one, e.many}));
                chk(hit_valid == e.hv, "R6", "hit_valid", int'(hit_valid), int'(e.hv));
                if (e.hv) chk(hit_index == e.hidx, "R6", "hit_index", int'(hit_index), e.hidx);
                if (e.is_read) begin
                    chk(rd_valid == e.rdv, "R5", "rd_valid", int'(rd_valid), int'(e.rdv));
                    chk(rd_data == e.rdd, "R5", "rd_data", int'(rd_data), int'(e.rdd));
                end
                chk(full == e.full, "R8", "full", int'(full), int'(e.full));
            end
        end
    end

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] fill [8];
        logic [N-1:0] held;
        fill = '{8'h12, 8'h34, 8'h3A, 8'h56, 8'h78, 8'h9C, 8'h3F, 8'hA0};
        for (int j = 0; j < N; j++) begin m_data[j] = '0; m_occ[j] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(hit_vec == 0 && hit_count == 0, "R1", "vec/count", int'(hit_vec), 0);
        chk(st_none && !st_one && !st_many && !hit_valid, "R1", "flags",
            int'({st_none, st_one, st_many, hit_valid}), 8);
        chk(!rd_valid && !full && !op_done, "R1", "pulses",
            int'({rd_valid, full, op_done}), 0);

        issue(1, 8'h00, 8'hFF, 0);    // R2: free zero cells hit a zero key
        issue(2, 8'h05, 8'hFF, 0);    // R5: cancelled read
        for (int i = 0; i < 8; i++) issue(3, 0, 0, fill[i]);   // R7: fill lowest free
        issue(1, 8'h34, 8'hFF, 0);    // R4 one hit
        issue(2, 8'h30, 8'hF0, 0);    // R5/R6 several hits, lowest returned
        issue(1, 8'h00, 8'h00, 0);    // R2 mask zero: all hit
        issue(2, 8'hA0, 8'hFF, 0);    // R5 single hit at top cell
        issue(3, 0, 0, 8'hEE);        // R8: full
        issue(1, 8'hEE, 8'hFF, 0);    // R8: refused word absent
        issue(2, 8'h0C, 8'h0F, 0);    // R2 partial low-nibble mask

        // R9: idle and no-op cycles hold results
        @(negedge clk);
        held = hit_vec;
        cmd_valid = 1; cmd_op = 0; key = 8'h12; mask = 8'hFF;
        repeat (3) @(negedge clk);
        chk(hit_vec == held, "R9", "hit_vec held", int'(hit_vec), int'(held));
        chk(!op_done && !rd_valid && !full, "R9", "pulses idle",
            int'({op_done, rd_valid, full}), 0);
        cmd_valid = 0;
        repeat (2) @(negedge clk);
        chk(sb_q.size() == 0, "R2", "scoreboard drained", sb_q.size(), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule